// File: doc/BRIEF.md
# Adaptive Parity Span and Protection Mode Controller

This block sits beside the receive-side decoder of a parity-product protected link. After each packet (or group of flits) the decoder reports two counts: how many flits failed their per-flit parity and how many bit positions failed the column parity. From those reports the controller chooses one of three protection modes and keeps the span, the number of flits covered by one parity flit, inside a bounded power-of-two range.

In the adaptive mode the parity flit is sent only on demand, plus once every span flits. Clean packets double the span and faulty ones halve it. When the span comes back to the buffer limit, the controller falls back to full product coding. Full coding returns to the adaptive mode after a clean packet and escalates to a high-error mode after a multi-fault packet. In the high-error mode a further multi-fault packet raises an alert. While the adaptive mode is active, an unfixable flit parity failure produces a one-cycle request for the parity flit. The mode and span outputs are meant to be carried to the far end by other logic.

Top module: `ppc_mode_ctrl`

## Requirements
- R1: After reset the mode output is 2 (full coding), the span equals K (default 4), and the parity request and alert outputs are 0.
- R2: The mode output takes only the codes 1 (adaptive), 2 (full coding) and 3 (high error). The span output is always a power of two within [M_MIN, M_MAX] (defaults 1 and 64).
- R3: In the adaptive mode, a valid result with zero faulty flits and zero faulty bit positions doubles the span on the next cycle. The span saturates at M_MAX.
- R4: In the adaptive mode, any other valid result halves the span. The span saturates at M_MIN.
- R5: In the adaptive mode, if the updated span equals K, the mode becomes full coding on the same clock edge.
- R6: In full coding mode, a clean valid result switches to the adaptive mode and leaves the span unchanged.
- R7: In full coding mode, a valid result with two or more faulty flits, or two or more faulty bit positions, switches to the high-error mode. A result with at most one of each keeps full coding. The span never changes outside the adaptive mode.
- R8: In the high-error mode, a valid result with at most one faulty flit and at most one faulty bit position returns to full coding and clears the alert.
- R9: In the high-error mode, a valid result with two or more faulty flits or bit positions raises the alert and keeps the high-error mode. The alert then stays high until the mode leaves high-error.
- R10: The parity request is high for exactly the one cycle after an unfixable-flit strobe that was sampled while the mode was adaptive. The mode used is the one in force before any update on that same edge. Otherwise the request is 0.
- R11: With the result-valid strobe low, mode, span and alert hold their values, whatever the counts are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_vld | input | 1 | One-cycle strobe: a packet decode result is present |
| bad_flits | input | CNT_W | Number of flits with failed flit parity |
| bad_bits | input | CNT_W | Number of bit positions with failed column parity |
| flit_unfixed | input | 1 | Strobe: a flit parity failure could not be fixed locally |
| mode_o | output | 2 | Current mode: 1 adaptive, 2 full coding, 3 high error |
| span_o | output | SPAN_W | Current span M (flits per parity flit) |
| par_req_o | output | 1 | Request to the sender for a parity flit |
| high_err_o | output | 1 | High error rate alert |

## Verification
Two functions can fall in the same cycle: an unfixable-flit strobe and a result that changes the mode. The bench provokes this twice. In the first case, a clean result in full coding arrives together with the strobe, so the mode moves to adaptive but no request may follow. In the second, a faulty result in the adaptive mode brings the span back to K alongside the strobe, so the request must appear while the mode is already reported as full coding. A scoreboard model that decides the request from the mode in force before the edge judges both cases.

// File: rtl/ppc_mode_pkg.sv
package ppc_mode_pkg;

  typedef enum logic [1:0] {
    MODE_ADAPT = 2'd1,
    MODE_FULL  = 2'd2,
    MODE_HIGH  = 2'd3
  } mode_e;

  // no fault at all in the packet
  function automatic logic is_clean(input logic [31:0] flits, input logic [31:0] bits);
    return (flits == 32'd0) && (bits == 32'd0);
  endfunction

  // more than one fault in either dimension
  function automatic logic is_heavy(input logic [31:0] flits, input logic [31:0] bits);
    return (flits >= 32'd2) || (bits >= 32'd2);
  endfunction

  function automatic logic [31:0] span_grow(input logic [31:0] m, input logic [31:0] hi);
    return (m >= hi) ? hi : (m << 1);
  endfunction

  function automatic logic [31:0] span_shrink(input logic [31:0] m, input logic [31:0] lo);
    return (m <= lo) ? lo : (m >> 1);
  endfunction

endpackage

// File: rtl/ppc_span_reg.sv
module ppc_span_reg #(
  parameter int unsigned M_MIN  = 1,
  parameter int unsigned M_MAX  = 64,
  parameter int unsigned K      = 4,
  parameter int unsigned SPAN_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic              clean,
  output logic [SPAN_W-1:0] span_q,
  output logic [SPAN_W-1:0] span_nxt
);
  import ppc_mode_pkg::*;

  logic [31:0] grown;
  logic [31:0] shrunk;

  assign grown    = span_grow(32'(span_q), 32'(M_MAX));
  assign shrunk   = span_shrink(32'(span_q), 32'(M_MIN));
  assign span_nxt = !upd_en ? span_q : (clean ? SPAN_W'(grown) : SPAN_W'(shrunk));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) span_q <= SPAN_W'(K);
    else        span_q <= span_nxt;
  end

  // R2: span stays a power of two inside its bounds
  a_r2_span_legal: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(span_q) && (32'(span_q) >= M_MIN) && (32'(span_q) <= M_MAX));

  // R11: no update request, no span change
  a_r11_span_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(span_q));

endmodule

// File: rtl/ppc_mode_fsm.sv
module ppc_mode_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic valid,
  input  logic clean,
  input  logic heavy,
  input  logic span_hits_k,
  output ppc_mode_pkg::mode_e mode_q,
  output logic alert_q
);
  import ppc_mode_pkg::*;

  mode_e mode_nxt;
  logic  alert_nxt;
  logic  hi_bad_evt;

  assign hi_bad_evt = valid && (mode_q == MODE_HIGH) && heavy;

  always_comb begin
    mode_nxt = mode_q;
    if (valid) begin
      unique case (mode_q)
        MODE_ADAPT: if (span_hits_k) mode_nxt = MODE_FULL;
        MODE_FULL: begin
          if (clean)      mode_nxt = MODE_ADAPT;
          else if (heavy) mode_nxt = MODE_HIGH;
        end
        MODE_HIGH: if (!heavy) mode_nxt = MODE_FULL;
        default:   mode_nxt = MODE_FULL;
      endcase
    end
  end

  assign alert_nxt = (mode_nxt == MODE_HIGH) && (alert_q || hi_bad_evt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_FULL;
      alert_q <= 1'b0;
    end else begin
      mode_q  <= mode_nxt;
      alert_q <= alert_nxt;
    end
  end

  // R2: only the three legal codes
  a_r2_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q != 2'd0);

  // R9: alert only while in high-error mode
  a_r9_alert_in_high: assert property (@(posedge clk) disable iff (!rst_n)
    alert_q |-> (mode_q == MODE_HIGH));

  // R9: a heavy result in high-error mode raises the alert
  a_r9_alert_raise: assert property (@(posedge clk) disable iff (!rst_n)
    hi_bad_evt |=> alert_q && (mode_q == MODE_HIGH));

  // R11: no result, no mode change
  a_r11_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> $stable(mode_q) && $stable(alert_q));

endmodule

// File: rtl/ppc_req_gen.sv
module ppc_req_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic fail_stb,
  input  logic adaptive,
  output logic req_q
);
  logic req_evt;

  assign req_evt = fail_stb && adaptive;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_evt;
  end

  // R10: a request always follows a strobe taken in the adaptive mode
  a_r10_req_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_evt |=> req_q);

  // R10: the request lasts one cycle unless retriggered
  a_r10_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !req_evt) |=> !req_q);

endmodule

// File: rtl/ppc_mode_ctrl.sv
module ppc_mode_ctrl #(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned M_MIN  = 1,
  parameter int unsigned M_MAX  = 64,
  parameter int unsigned K      = 4,
  parameter int unsigned SPAN_W = $clog2(M_MAX) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_vld,
  input  logic [CNT_W-1:0]  bad_flits,
  input  logic [CNT_W-1:0]  bad_bits,
  input  logic              flit_unfixed,
  output logic [1:0]        mode_o,
  output logic [SPAN_W-1:0] span_o,
  output logic              par_req_o,
  output logic              high_err_o
);
  import ppc_mode_pkg::*;

  mode_e             mode_q;
  logic              res_clean;
  logic              res_heavy;
  logic              in_adapt;
  logic              span_upd;
  logic              span_hits_k;
  logic [SPAN_W-1:0] span_q;
  logic [SPAN_W-1:0] span_nxt;

  assign res_clean   = is_clean(32'(bad_flits), 32'(bad_bits));
  assign res_heavy   = is_heavy(32'(bad_flits), 32'(bad_bits));
  assign in_adapt    = (mode_q == MODE_ADAPT);
  assign span_upd    = res_vld && in_adapt;
  assign span_hits_k = (32'(span_nxt) == K);

  ppc_span_reg #(.M_MIN(M_MIN), .M_MAX(M_MAX), .K(K), .SPAN_W(SPAN_W)) u_span (
    .clk(clk), .rst_n(rst_n), .upd_en(span_upd), .clean(res_clean),
    .span_q(span_q), .span_nxt(span_nxt)
  );

  ppc_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .valid(res_vld), .clean(res_clean),
    .heavy(res_heavy), .span_hits_k(span_hits_k),
    .mode_q(mode_q), .alert_q(high_err_o)
  );

  ppc_req_gen u_req (
    .clk(clk), .rst_n(rst_n), .fail_stb(flit_unfixed),
    .adaptive(in_adapt), .req_q(par_req_o)
  );

  assign mode_o = mode_q;
  assign span_o = span_q;

  // R5: reaching K in the adaptive mode falls back to full coding
  a_r5_back_to_full: assert property (@(posedge clk) disable iff (!rst_n)
    (span_upd && span_hits_k) |=> (mode_q == MODE_FULL));

  // R7: the span is frozen outside the adaptive mode
  a_r7_span_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !in_adapt |=> $stable(span_q));

  // R6: clean result in full coding enters adaptive with span kept
  a_r6_full_to_adapt: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && res_clean && mode_q == MODE_FULL) |=> (mode_q == MODE_ADAPT) && $stable(span_q));

  // R10: a request only follows a cycle spent in the adaptive mode
  a_r10_req_source: assert property (@(posedge clk) disable iff (!rst_n)
    par_req_o |-> $past(mode_q) == MODE_ADAPT);

endmodule

// File: tb/tb_ppc_mode_ctrl.sv
module tb_ppc_mode_ctrl;

  localparam int unsigned CW = 8;
  localparam int unsigned SW = 7;
  localparam int unsigned KV = 4;

  typedef struct {
    int    mode;
    int    span;
    bit    req;
    bit    alert;
    string tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          res_vld = 1'b0;
  logic [CW-1:0] bad_flits = '0;
  logic [CW-1:0] bad_bits = '0;
  logic          flit_unfixed = 1'b0;
  logic [1:0]    mode_o;
  logic [SW-1:0] span_o;
  logic          par_req_o;
  logic          high_err_o;

  int   total = 0;
  int   bad   = 0;
  exp_t sb[$];

  // model state
  int em = 2;
  int es = KV;
  bit ea = 1'b0;

  always #2.5 clk = ~clk;

  ppc_mode_ctrl dut (
    .clk(clk), .rst_n(rst_n), .res_vld(res_vld), .bad_flits(bad_flits),
    .bad_bits(bad_bits), .flit_unfixed(flit_unfixed), .mode_o(mode_o),
    .span_o(span_o), .par_req_o(par_req_o), .high_err_o(high_err_o)
  );

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // drive one cycle and push the expected outputs after the edge
  task automatic step(input bit v, input int f, input int b, input bit fail, input string tag);
    exp_t e;
    bit   clean;
    bit   heavy;
    @(negedge clk);
    res_vld = v; bad_flits = CW'(f); bad_bits = CW'(b); flit_unfixed = fail;
    clean = (f == 0) && (b == 0);
    heavy = (f > 1) || (b > 1);
    e.req = fail && (em == 1);
    if (v) begin
      if (em == 1) begin
        if (clean) es = (es * 2 > 64) ? 64 : es * 2;
        else       es = (es / 2 < 1) ? 1 : es / 2;
        if (es == KV) em = 2;
      end else if (em == 2) begin
        if (clean)      em = 1;
        else if (heavy) em = 3;
      end else begin
        if (!heavy) begin em = 2; ea = 1'b0; end
        else        ea = 1'b1;
      end
    end
    e.mode = em; e.span = es; e.alert = ea; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: compare right after each edge, well away from the next one
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(int'(mode_o) == e.mode, e.tag, "mode", int'(mode_o), e.mode);
        check(int'(span_o) == e.span, e.tag, "span", int'(span_o), e.span);
        check(par_req_o == e.req, e.tag, "req", int'(par_req_o), int'(e.req));
        check(high_err_o == e.alert, e.tag, "alert", int'(high_err_o), int'(e.alert));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(mode_o == 2'd2, "R1", "mode", int'(mode_o), 2);
    check(int'(span_o) == KV, "R1", "span", int'(span_o), KV);
    check(par_req_o == 1'b0 && high_err_o == 1'b0, "R1", "req|alert",
          int'(par_req_o | high_err_o), 0);
    @(negedge clk); rst_n = 1'b1;

    step(1, 0, 0, 0, "R6 full clean");
    step(0, 0, 0, 1, "R10 strobe adaptive");
    step(0, 0, 0, 0, "R10 pulse ends");
    for (int i = 0; i < 5; i++) step(1, 0, 0, 0, "R3 grow");
    step(0, 3, 3, 0, "R11 no strobe");
    step(1, 1, 0, 0, "R4 shrink");
    step(1, 0, 1, 0, "R4 shrink");
    step(1, 2, 0, 0, "R4 shrink");
    step(1, 1, 1, 0, "R5 reach K");
    step(1, 0, 0, 0, "R6 to adapt");
    step(1, 1, 0, 0, "R4 below K");
    step(1, 0, 2, 0, "R4 to min");
    step(1, 1, 0, 0, "R4 min saturate");
    step(1, 0, 0, 0, "R3 grow from min");
    step(1, 0, 0, 0, "R5 grow to K");
    step(1, 1, 1, 0, "R7 single fault stays");
    step(1, 0, 2, 0, "R7 heavy to high");
    step(1, 1, 1, 0, "R8 back to full");
    step(1, 2, 0, 0, "R7 heavy to high");
    step(1, 2, 0, 0, "R9 alert raise");
    step(0, 5, 5, 1, "R11 hold in high");
    step(1, 3, 3, 0, "R9 alert held");
    step(1, 0, 1, 1, "R8 clear alert");
    step(1, 0, 0, 1, "R10 clean plus strobe in full");
    step(1, 0, 0, 1, "R10 grow plus strobe");
    step(1, 1, 0, 1, "R10 to full plus strobe");
    step(0, 0, 0, 1, "R10 strobe in full");
    step(0, 0, 0, 0, "R2 idle");
    repeat (3) @(posedge clk);
    #2;
    check(sb.size() == 0, "R2", "queue", sb.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule